// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Not-Recently-Used Replacement

The block holds a small set of address translations. Each one maps a virtual page to a physical page. Every stored entry carries:

- a virtual page number, aligned to its own page size;
- a partition identifier and a context identifier;
- a real-mode flag;
- a two-bit page-size code;
- a physical page number;
- a lock bit, a used bit and a valid bit.

A combinational lookup port compares a virtual address and its identifiers against all entries at once. It returns a hit flag, the index of the matching entry and the translated physical address.

One management command is accepted per clock. The commands are:

- insert, at a given index or at an automatically chosen victim;
- drop a single page;
- drop a whole context;
- drop every unlocked entry of a partition;
- invalidate everything.

An indexed read port returns each entry as a packed tag word and a packed data word. Victim choice follows a not-recently-used scheme. A used bit is set on insert. When every used bit is set, the used bits are swept clear, except on locked entries and on the entry just written. Inserting a translation also removes any older copy with the same key.

Page-size codes are 0, 1, 2 and 3. They stand for 8 KB, 64 KB, 4 MB and 256 MB pages, which ignore the lowest 13, 16, 22 and 28 virtual-address bits. The command port carries the virtual page number, which is the virtual address shifted right by 13. The command encoding on `op_i` is:

| Code | Command |
|---|---|
| 0 | idle |
| 1 | insert |
| 2 | demap page |
| 3 | demap context |
| 4 | demap partition |
| 5 | invalidate all |
| 6, 7 | idle |

Top module: `tlb_nru`

## Requirements
- R1: After reset no entry is valid, the lookup reports a miss, and every data word reads zero.
- R2: A lookup hits an entry only if all of the following hold: the entry is valid; its partition, context and real flag equal the lookup's; and the lookup address equals the stored page outside the bits its size code ignores. On a hit the port returns the lowest matching index and the physical address. That address is the stored physical page, with its ignored low page bits replaced by the lookup's, followed by the lookup address bits 12..0. On a miss the physical address output is zero.
- R3: An insert with `op_at_idx_i` set writes the entry at `op_idx_i`. An index at or above the entry count selects the last entry.
- R4: An insert with `op_at_idx_i` clear writes the lowest-index entry that is invalid or has a clear used bit. When no entry qualifies, it writes entry N_ENTRIES-1.
- R5: An inserted entry becomes valid and used. Other valid entries are invalidated and have their used bit cleared if they match the new entry on all of these: aligned page, size, partition, context and real flag.
- R6: When every used bit is set after an insert, the used bits of all unlocked entries other than the one just written are cleared. A used bit is never set on an invalid entry.
- R7: Demap page invalidates the valid entries whose partition, context and real flag match the command's and whose page covers the command's page.
- R8: Demap context invalidates every entry whose partition and context both match, locked ones included.
- R9: Demap partition invalidates only the unlocked entries of the given partition.
- R10: Invalidate all clears the valid and used bits of every entry.
- R11: The tag word layout is: context in bits 12..0, aligned virtual page in bits 47..13, real flag in bit 60, partition in bits 63..61, inverted size code in bits 57..56, and zeros elsewhere.
- R12: The data word layout is: valid in bit 63, lock in bit 62, used in bit 61, size code in bits 57..56, physical page in bits 39..13, and zeros elsewhere.
- R13: Every command takes effect at the next clock edge. A lookup in the same cycle as a command sees the state from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command code |
| op_vpn_i | input | 35 | Virtual page number for insert and demap page |
| op_pid_i | input | 3 | Partition for the command |
| op_ctx_i | input | 13 | Context for the command |
| op_real_i | input | 1 | Real-mode flag for the command |
| op_size_i | input | 2 | Page-size code for insert |
| op_ppn_i | input | 27 | Physical page number for insert |
| op_lock_i | input | 1 | Lock bit for insert |
| op_at_idx_i | input | 1 | Insert uses op_idx_i instead of the victim search |
| op_idx_i | input | 3 | Explicit insert index |
| lk_va_i | input | 48 | Lookup virtual address |
| lk_pid_i | input | 3 | Lookup partition |
| lk_ctx_i | input | 13 | Lookup context |
| lk_real_i | input | 1 | Lookup real-mode flag |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | 3 | Index of the lowest matching entry |
| lk_pa_o | output | 40 | Translated physical address |
| rd_idx_i | input | 3 | Entry index for the read port |
| rd_tag_o | output | 64 | Packed tag word of the addressed entry |
| rd_data_o | output | 64 | Packed data word of the addressed entry |

## Verification
A lookup and a management command can fall in the same clock cycle. The lookup must then reflect the entries as they stood before the command's edge. The bench provokes this with a 4 MB translation in place: it issues invalidate-all and a lookup inside that page together. It samples the lookup once before the clock edge, where a hit is expected, and once after, where a miss is expected. Every table row also pairs its command with a lookup that is observed only after the edge, so that row's result comes from the updated state.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned VA_W  = 48;
  parameter int unsigned PA_W  = 40;
  parameter int unsigned CTX_W = 13;
  parameter int unsigned PID_W = 3;
  parameter int unsigned PG_SH = 13;
  parameter int unsigned SZ_W  = 2;
  localparam int unsigned VPN_W = VA_W - PG_SH;
  localparam int unsigned PPN_W = PA_W - PG_SH;
  localparam int unsigned SUB_W = 15;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_INSERT     = 3'd1,
    OP_DEMAP_PAGE = 3'd2,
    OP_DEMAP_CTX  = 3'd3,
    OP_DEMAP_PART = 3'd4,
    OP_FLUSH      = 3'd5
  } tlb_op_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [CTX_W-1:0] ctx;
    logic             real_m;
    logic [SZ_W-1:0]  size;
    logic [PPN_W-1:0] ppn;
    logic             lock;
  } tlb_ent_t;

  // page-number bits ignored by each size code
  function automatic logic [SUB_W-1:0] sub_mask(input logic [SZ_W-1:0] sz);
    case (sz)
      2'd0:    sub_mask = 15'h0000;
      2'd1:    sub_mask = 15'h0007;
      2'd2:    sub_mask = 15'h01ff;
      default: sub_mask = 15'h7fff;
    endcase
  endfunction
endpackage

// File: rtl/tlb_lowest.sv
module tlb_lowest #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_cmp.sv
module tlb_cmp import tlb_pkg::*; (
  input  tlb_ent_t         ent_i,
  input  logic             valid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [PID_W-1:0] lk_pid_i,
  input  logic [CTX_W-1:0] lk_ctx_i,
  input  logic             lk_real_i,
  input  logic [VPN_W-1:0] op_vpn_i,
  input  logic [VPN_W-1:0] op_vpn_al_i,
  input  logic [PID_W-1:0] op_pid_i,
  input  logic [CTX_W-1:0] op_ctx_i,
  input  logic             op_real_i,
  input  logic [SZ_W-1:0]  op_size_i,
  output logic             lk_hit_o,
  output logic             page_hit_o,
  output logic             key_eq_o,
  output logic             ctx_eq_o,
  output logic             part_eq_o
);
  logic [VPN_W-1:0] ign;
  logic             lk_id, op_id;

  assign ign   = VPN_W'(sub_mask(ent_i.size));
  assign lk_id = (ent_i.pid == lk_pid_i) && (ent_i.ctx == lk_ctx_i) && (ent_i.real_m == lk_real_i);
  assign op_id = (ent_i.pid == op_pid_i) && (ent_i.ctx == op_ctx_i) && (ent_i.real_m == op_real_i);

  assign lk_hit_o   = valid_i && lk_id && (((lk_vpn_i ^ ent_i.vpn) & ~ign) == '0);
  assign page_hit_o = valid_i && op_id && (((op_vpn_i ^ ent_i.vpn) & ~ign) == '0);
  assign key_eq_o   = valid_i && op_id && (ent_i.vpn == op_vpn_al_i) && (ent_i.size == op_size_i);
  assign ctx_eq_o   = (ent_i.pid == op_pid_i) && (ent_i.ctx == op_ctx_i);
  assign part_eq_o  = (ent_i.pid == op_pid_i);
endmodule

// File: rtl/tlb_fmt.sv
module tlb_fmt import tlb_pkg::*; (
  input  tlb_ent_t    ent_i,
  input  logic        valid_i,
  input  logic        used_i,
  output logic [63:0] tag_o,
  output logic [63:0] data_o
);
  always_comb begin
    tag_o = '0;
    tag_o[CTX_W-1:0]       = ent_i.ctx;
    tag_o[VA_W-1:PG_SH]    = tag_o[VA_W-1:PG_SH] | ent_i.vpn;
    tag_o[61 +: PID_W]     = ent_i.pid;
    tag_o[60]              = ent_i.real_m;
    tag_o[56 +: SZ_W]      = ~ent_i.size;

    data_o = '0;
    data_o[63]             = valid_i;
    data_o[62]             = ent_i.lock;
    data_o[61]             = used_i;
    data_o[56 +: SZ_W]     = ent_i.size;
    data_o[PA_W-1:PG_SH]   = ent_i.ppn;
  end
endmodule

// File: rtl/tlb_nru.sv
module tlb_nru import tlb_pkg::*; #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         op_i,
  input  logic [VPN_W-1:0]   op_vpn_i,
  input  logic [PID_W-1:0]   op_pid_i,
  input  logic [CTX_W-1:0]   op_ctx_i,
  input  logic               op_real_i,
  input  logic [SZ_W-1:0]    op_size_i,
  input  logic [PPN_W-1:0]   op_ppn_i,
  input  logic               op_lock_i,
  input  logic               op_at_idx_i,
  input  logic [IDX_W-1:0]   op_idx_i,
  input  logic [VA_W-1:0]    lk_va_i,
  input  logic [PID_W-1:0]   lk_pid_i,
  input  logic [CTX_W-1:0]   lk_ctx_i,
  input  logic               lk_real_i,
  output logic               lk_hit_o,
  output logic [IDX_W-1:0]   lk_idx_o,
  output logic [PA_W-1:0]    lk_pa_o,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [63:0]        rd_tag_o,
  output logic [63:0]        rd_data_o
);
  localparam int unsigned N = N_ENTRIES;

  if (N > 64 || N < 2) begin : g_bad_size
    $error("tlb_nru: N_ENTRIES must lie in 2..64");
  end

  tlb_op_e          op;
  tlb_ent_t         ent_q [N];
  tlb_ent_t         new_ent;
  logic [N-1:0]     valid_q, used_q, lock_q;
  logic [N-1:0]     valid_d, used_d, lock_nx;
  logic [N-1:0]     lk_hit_v, page_v, key_v, ctx_v, part_v, cand_v, vict_oh;
  logic [VPN_W-1:0] lk_vpn, op_vpn_al;
  logic [IDX_W-1:0] cand_idx, at_idx, victim_idx;
  logic             cand_found;

  assign op        = tlb_op_e'(op_i);
  assign lk_vpn    = lk_va_i[VA_W-1:PG_SH];
  assign op_vpn_al = op_vpn_i & ~VPN_W'(sub_mask(op_size_i));

  assign new_ent = '{vpn: op_vpn_al, pid: op_pid_i, ctx: op_ctx_i, real_m: op_real_i,
                     size: op_size_i, ppn: op_ppn_i, lock: op_lock_i};

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign lock_q[g] = ent_q[g].lock;
    tlb_cmp i_cmp (
      .ent_i       (ent_q[g]),
      .valid_i     (valid_q[g]),
      .lk_vpn_i    (lk_vpn),
      .lk_pid_i    (lk_pid_i),
      .lk_ctx_i    (lk_ctx_i),
      .lk_real_i   (lk_real_i),
      .op_vpn_i    (op_vpn_i),
      .op_vpn_al_i (op_vpn_al),
      .op_pid_i    (op_pid_i),
      .op_ctx_i    (op_ctx_i),
      .op_real_i   (op_real_i),
      .op_size_i   (op_size_i),
      .lk_hit_o    (lk_hit_v[g]),
      .page_hit_o  (page_v[g]),
      .key_eq_o    (key_v[g]),
      .ctx_eq_o    (ctx_v[g]),
      .part_eq_o   (part_v[g])
    );
  end

  // lookup: lowest matching entry wins
  tlb_lowest #(.N(N), .IW(IDX_W)) i_lk_enc (
    .req_i   (lk_hit_v),
    .found_o (lk_hit_o),
    .idx_o   (lk_idx_o)
  );

  always_comb begin
    logic [PPN_W-1:0] page;
    logic [SUB_W-1:0] m;
    m    = sub_mask(ent_q[lk_idx_o].size);
    page = ent_q[lk_idx_o].ppn;
    page[SUB_W-1:0] = (page[SUB_W-1:0] & ~m) | (lk_vpn[SUB_W-1:0] & m);
    lk_pa_o = lk_hit_o ? {page, lk_va_i[PG_SH-1:0]} : '0;
  end

  // victim: first invalid or not-recently-used entry, else the last one
  assign cand_v = ~valid_q | ~used_q;

  tlb_lowest #(.N(N), .IW(IDX_W)) i_vict_enc (
    .req_i   (cand_v),
    .found_o (cand_found),
    .idx_o   (cand_idx)
  );

  if ((1 << IDX_W) == N) begin : g_idx_full
    assign at_idx = op_idx_i;
  end else begin : g_idx_clamp
    assign at_idx = (op_idx_i > IDX_W'(N - 1)) ? IDX_W'(N - 1) : op_idx_i;
  end

  assign victim_idx = op_at_idx_i ? at_idx : (cand_found ? cand_idx : IDX_W'(N - 1));
  assign vict_oh    = {{(N-1){1'b0}}, 1'b1} << victim_idx;

  always_comb begin
    valid_d = valid_q;
    used_d  = used_q;
    lock_nx = lock_q;
    case (op)
      OP_INSERT: begin
        valid_d = (valid_q & ~(key_v & ~vict_oh)) | vict_oh;
        used_d  = (used_q  & ~(key_v & ~vict_oh)) | vict_oh;
        lock_nx[victim_idx] = op_lock_i;
        if (&used_d) used_d = lock_nx | vict_oh;
      end
      OP_DEMAP_PAGE: begin
        valid_d = valid_q & ~page_v;
        used_d  = used_q  & ~page_v;
      end
      OP_DEMAP_CTX: begin
        valid_d = valid_q & ~ctx_v;
        used_d  = used_q  & ~ctx_v;
      end
      OP_DEMAP_PART: begin
        valid_d = valid_q & ~(part_v & ~lock_q);
        used_d  = used_q  & ~(part_v & ~lock_q);
      end
      OP_FLUSH: begin
        valid_d = '0;
        used_d  = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      used_q  <= '0;
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else begin
      valid_q <= valid_d;
      used_q  <= used_d;
      if (op == OP_INSERT) ent_q[victim_idx] <= new_ent;
    end
  end

  tlb_fmt i_fmt (
    .ent_i   (ent_q[rd_idx_i]),
    .valid_i (valid_q[rd_idx_i]),
    .used_i  (used_q[rd_idx_i]),
    .tag_o   (rd_tag_o),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/tlb_nru_chk.sv
module tlb_nru_chk import tlb_pkg::*; #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           op_i,
  input logic [N_ENTRIES-1:0] valid_q,
  input logic [N_ENTRIES-1:0] used_q,
  input logic [N_ENTRIES-1:0] lock_q,
  input logic                 lk_hit_o,
  input logic [IDX_W-1:0]     lk_idx_o,
  input logic [IDX_W-1:0]     victim_idx
);
  assert_hit_is_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> valid_q[lk_idx_o]);

  assert_insert_marks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'(OP_INSERT)) |=> (valid_q[$past(victim_idx)] && used_q[$past(victim_idx)]));

  assert_used_needs_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((used_q & ~valid_q) == '0));

  assert_part_keeps_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'(OP_DEMAP_PART)) |=> ((valid_q & $past(lock_q)) == $past(valid_q & lock_q)));

  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'(OP_FLUSH)) |=> (valid_q == '0 && used_q == '0));
endmodule

bind tlb_nru tlb_nru_chk #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .valid_q    (valid_q),
  .used_q     (used_q),
  .lock_q     (lock_q),
  .lk_hit_o   (lk_hit_o),
  .lk_idx_o   (lk_idx_o),
  .victim_idx (victim_idx)
);

// File: tb/test_tlb_nru.sv
module test_tlb_nru;
  import tlb_pkg::*;

  localparam int N = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       op_i = '0;
  logic [VPN_W-1:0] op_vpn_i = '0;
  logic [PID_W-1:0] op_pid_i = '0;
  logic [CTX_W-1:0] op_ctx_i = 13'd5;
  logic             op_real_i = 1'b0;
  logic [SZ_W-1:0]  op_size_i = '0;
  logic [PPN_W-1:0] op_ppn_i = '0;
  logic             op_lock_i = 1'b0;
  logic             op_at_idx_i = 1'b0;
  logic [2:0]       op_idx_i = '0;
  logic [VA_W-1:0]  lk_va_i = '0;
  logic [PID_W-1:0] lk_pid_i = '0;
  logic [CTX_W-1:0] lk_ctx_i = 13'd5;
  logic             lk_real_i = 1'b0;
  logic             lk_hit_o;
  logic [2:0]       lk_idx_o;
  logic [PA_W-1:0]  lk_pa_o;
  logic [2:0]       rd_idx_i = '0;
  logic [63:0]      rd_tag_o, rd_data_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk; // 20 ns period

  tlb_nru #(.N_ENTRIES(N)) i_tlb_nru (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .op_vpn_i(op_vpn_i), .op_pid_i(op_pid_i),
    .op_ctx_i(op_ctx_i), .op_real_i(op_real_i), .op_size_i(op_size_i), .op_ppn_i(op_ppn_i),
    .op_lock_i(op_lock_i), .op_at_idx_i(op_at_idx_i), .op_idx_i(op_idx_i),
    .lk_va_i(lk_va_i), .lk_pid_i(lk_pid_i), .lk_ctx_i(lk_ctx_i), .lk_real_i(lk_real_i),
    .lk_hit_o(lk_hit_o), .lk_idx_o(lk_idx_o), .lk_pa_o(lk_pa_o),
    .rd_idx_i(rd_idx_i), .rd_tag_o(rd_tag_o), .rd_data_o(rd_data_o)
  );

  typedef struct packed {
    logic [2:0]       op;
    logic [VPN_W-1:0] vpn;
    logic [2:0]       pid;
    logic [1:0]       sz;
    logic [PPN_W-1:0] ppn;
    logic             lk;
    logic             at;
    logic [2:0]       idx;
    logic [VA_W-1:0]  qva;
    logic [2:0]       qpid;
    logic             qhit;
    logic [2:0]       qidx;
    logic [3:0]       rq;
  } row_t;

  // op: 0 idle, 1 insert, 2 demap page, 3 demap ctx, 4 demap partition
  localparam row_t ROWS [22] = '{
    '{3'd1, 35'd1,  3'd1, 2'd0, 27'h101, 1'b0, 1'b0, 3'd0, 48'h02000, 3'd1, 1'b1, 3'd0, 4'd4}, // R4
    '{3'd1, 35'd2,  3'd1, 2'd0, 27'h102, 1'b0, 1'b0, 3'd0, 48'h04000, 3'd1, 1'b1, 3'd1, 4'd4},
    '{3'd1, 35'd3,  3'd1, 2'd0, 27'h103, 1'b0, 1'b0, 3'd0, 48'h06000, 3'd1, 1'b1, 3'd2, 4'd4},
    '{3'd1, 35'd4,  3'd1, 2'd0, 27'h104, 1'b0, 1'b0, 3'd0, 48'h08000, 3'd1, 1'b1, 3'd3, 4'd4},
    '{3'd1, 35'd5,  3'd1, 2'd0, 27'h105, 1'b0, 1'b0, 3'd0, 48'h0a000, 3'd1, 1'b1, 3'd4, 4'd4},
    '{3'd1, 35'd6,  3'd1, 2'd0, 27'h106, 1'b0, 1'b0, 3'd0, 48'h0c000, 3'd1, 1'b1, 3'd5, 4'd4},
    '{3'd1, 35'd7,  3'd1, 2'd0, 27'h107, 1'b0, 1'b0, 3'd0, 48'h0e000, 3'd1, 1'b1, 3'd6, 4'd4},
    '{3'd1, 35'd8,  3'd1, 2'd0, 27'h108, 1'b0, 1'b0, 3'd0, 48'h10000, 3'd1, 1'b1, 3'd7, 4'd4},
    '{3'd0, 35'd0,  3'd0, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h02000, 3'd1, 1'b1, 3'd0, 4'd6}, // R6 sweep keeps valid
    '{3'd1, 35'd9,  3'd1, 2'd0, 27'h109, 1'b0, 1'b0, 3'd0, 48'h12000, 3'd1, 1'b1, 3'd0, 4'd6}, // R6 swept slot reused
    '{3'd0, 35'd0,  3'd0, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h02000, 3'd1, 1'b0, 3'd0, 4'd4},
    '{3'd1, 35'd3,  3'd1, 2'd0, 27'h333, 1'b0, 1'b1, 3'd5, 48'h06000, 3'd1, 1'b1, 3'd5, 4'd5}, // R5 old copy gone
    '{3'd0, 35'd0,  3'd0, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h0c000, 3'd1, 1'b0, 3'd0, 4'd3}, // R3
    '{3'd1, 35'd10, 3'd1, 2'd0, 27'h10a, 1'b0, 1'b0, 3'd0, 48'h14000, 3'd1, 1'b1, 3'd1, 4'd4},
    '{3'd1, 35'd11, 3'd1, 2'd0, 27'h10b, 1'b1, 1'b0, 3'd0, 48'h16000, 3'd1, 1'b1, 3'd2, 4'd4},
    '{3'd1, 35'd12, 3'd2, 2'd0, 27'h10c, 1'b0, 1'b1, 3'd6, 48'h18000, 3'd2, 1'b1, 3'd6, 4'd3},
    '{3'd4, 35'd0,  3'd1, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h16000, 3'd1, 1'b1, 3'd2, 4'd9}, // R9 locked kept
    '{3'd0, 35'd0,  3'd0, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h18000, 3'd2, 1'b1, 3'd6, 4'd9}, // R9 other partition
    '{3'd0, 35'd0,  3'd0, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h12000, 3'd1, 1'b0, 3'd0, 4'd9},
    '{3'd3, 35'd0,  3'd1, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h16000, 3'd1, 1'b0, 3'd0, 4'd8}, // R8 locked dropped
    '{3'd0, 35'd0,  3'd0, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h18000, 3'd2, 1'b1, 3'd6, 4'd8},
    '{3'd2, 35'd12, 3'd2, 2'd0, 27'h000, 1'b0, 1'b0, 3'd0, 48'h18000, 3'd2, 1'b0, 3'd0, 4'd7}  // R7
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic look(input logic [VA_W-1:0] va, input logic [2:0] pid, input logic rl);
    lk_va_i = va; lk_pid_i = pid; lk_real_i = rl;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [VPN_W-1:0] vpn, input logic [2:0] pid,
                     input logic [1:0] sz, input logic [PPN_W-1:0] ppn, input logic lk,
                     input logic at, input logic [2:0] idx);
    @(negedge clk);
    op_i = op; op_vpn_i = vpn; op_pid_i = pid; op_size_i = sz; op_ppn_i = ppn;
    op_lock_i = lk; op_at_idx_i = at; op_idx_i = idx;
    @(posedge clk);
    @(negedge clk);
    op_i = 3'd0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    look(48'h2000, 3'd1, 1'b0);
    #1;
    chk("R1 hit", 64'(lk_hit_o), 64'd0);
    chk("R1 data", rd_data_o, 64'd0);
    rst_ni = 1'b1;

    for (int r = 0; r < 22; r++) begin
      look(ROWS[r].qva, ROWS[r].qpid, 1'b0);
      cmd(ROWS[r].op, ROWS[r].vpn, ROWS[r].pid, ROWS[r].sz, ROWS[r].ppn, ROWS[r].lk,
          ROWS[r].at, ROWS[r].idx);
      chk($sformatf("R%0d row %0d", ROWS[r].rq, r),
          64'({lk_hit_o, lk_hit_o ? lk_idx_o : 3'd0}), 64'({ROWS[r].qhit, ROWS[r].qidx}));
    end

    // R10 flush clears valid and used everywhere
    cmd(3'd5, '0, 3'd0, 2'd0, '0, 1'b0, 1'b0, 3'd0);
    for (int i = 0; i < N; i++) begin
      rd_idx_i = 3'(i);
      #1;
      chk("R10 flags", 64'(rd_data_o[63:61] & 3'b101), 64'd0);
    end

    // R2/R11/R12 large pages
    cmd(3'd1, 35'h200, 3'd1, 2'd2, 27'h1000, 1'b0, 1'b0, 3'd0);
    cmd(3'd1, 35'h18,  3'd1, 2'd1, 27'h208,  1'b0, 1'b0, 3'd0);
    look(48'h412345, 3'd1, 1'b0);
    #1;
    chk("R2 4M hit", 64'({lk_hit_o, lk_idx_o}), 64'({1'b1, 3'd0}));
    chk("R2 4M pa", 64'(lk_pa_o), 64'h2012345);
    look(48'h3f234, 3'd1, 1'b0);
    #1;
    chk("R2 64K pa", 64'(lk_pa_o), 64'h41f234);
    look(48'h812345, 3'd1, 1'b0);
    #1;
    chk("R2 outside page", 64'({lk_hit_o, lk_pa_o}), 64'd0);
    rd_idx_i = 3'd0;
    #1;
    chk("R11 tag", rd_tag_o, 64'h2100_0000_0040_0005);
    chk("R12 data", rd_data_o, 64'hA200_0000_0200_0000);

    // R13 lookup in the flush cycle sees old state
    @(negedge clk);
    look(48'h412345, 3'd1, 1'b0);
    op_i = 3'd5;
    #2;
    chk("R13 same cycle", 64'(lk_hit_o), 64'd1);
    @(posedge clk);
    @(negedge clk);
    op_i = 3'd0;
    chk("R13 after edge", 64'(lk_hit_o), 64'd0);

    // R4 all locked: last entry overwritten
    for (int k = 1; k <= 8; k++)
      cmd(3'd1, 35'(k), 3'd3, 2'd0, 27'(k), 1'b1, 1'b0, 3'd0);
    cmd(3'd1, 35'd20, 3'd3, 2'd0, 27'h77, 1'b0, 1'b0, 3'd0);
    look(48'h28000, 3'd3, 1'b0);
    #1;
    chk("R4 fallback", 64'({lk_hit_o, lk_idx_o}), 64'({1'b1, 3'd7}));
    look(48'h10000, 3'd3, 1'b0);
    #1;
    chk("R4 replaced", 64'(lk_hit_o), 64'd0);
    look(48'h2000, 3'd3, 1'b0);
    #1;
    chk("R6 locked kept", 64'({lk_hit_o, lk_idx_o}), 64'({1'b1, 3'd0}));
    look(48'h2000, 3'd3, 1'b1);
    #1;
    chk("R2 real flag", 64'(lk_hit_o), 64'd0);

    finish_run();
  end
endmodule